// File: doc/BRIEF.md
# Zoned Weighted-Field Read Sequencer

This block walks the read side of a bit-plane frame buffer that feeds a zoned LED panel. Every enabled cycle it presents one buffer address. The zone digit moves fastest, so a partition latch downstream can collect one word for every zone and then drive all zones at once. A one-cycle strobe tells that latch when the last zone of a group has been presented.

Grey scale comes from two mechanisms that work together. The heavy bit weights are shown as several equal-length sub-fields. A 19-step sub-field counter repeats the top plane eight times, the next plane four times, the next plane twice, and shows each remaining plane once. The light weights are shortened with a duty-cycle enable. A row timer is compared against a programmable on-time for the plane now being shown, and the enable it produces gates the panel's row drive.

The on-time values can be rewritten at any time through a small write port. This makes both brightness and the grey-scale curve adjustable.

Top module: `zone_field_sequencer`

## Requirements
- R1: While reset is applied, and until the first enabled cycle after it, the zone, row and column digits are 0, the sub-field step is 0, `zones_loaded` is low and `row_en` is high.
- R2: Each cycle with `run` high advances the zone digit by one. After zone 31 it returns to 0.
- R3: The column digit advances only in a cycle where the zone wraps from 31 to 0. After column COLS-1 (99, 63h, by default) it returns to 0.
- R4: The row digit advances only in a cycle where both the zone and the column wrap. After row 7 it returns to 0.
- R5: A sub-field step counter running 0 to 18 advances when zone, column and row all wrap. The field shown is 7 for steps 0–7, 6 for steps 8–11, 5 for steps 12–13 and 4 for step 14. Steps 15, 16, 17 and 18 show fields 3, 2, 1 and 0.
- R6: `rd_addr` is built from the field number in the top 3 bits, then the 5-bit zone, then the 3-bit row, and the column in the low bits (bits 17:15, 14:10, 9:7 and 6:0 by default). `zone_idx` equals the zone digit.
- R7: `zones_loaded` is high for exactly one cycle: the cycle after an enabled cycle in which the zone was 31. In that cycle `zone_idx` is 0.
- R8: A row timer counts enabled cycles since the start of the current row period, which is 32×COLS cycles long. `row_en` is high exactly while this timer is below the on-time value of the field being shown.
- R9: After reset the on-time values are the full row period for fields 7 to 2, half of it for field 1 and a quarter of it for field 0.
- R10: A cycle with `cfg_we` high stores `cfg_value` as the on-time of field `cfg_field`, and `row_en` uses the new value from the next cycle on. A value of 0 keeps `row_en` low for the whole of that field.
- R11: With `run` low, `rd_addr`, `zone_idx` and `row_en` hold their values and `zones_loaded` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| run | input | 1 | Advance enable; one address step per high cycle |
| cfg_we | input | 1 | On-time write strobe |
| cfg_field | input | FB (3) | Field whose on-time is written |
| cfg_value | input | TW (12) | New on-time in cycles |
| rd_addr | output | AW (18) | Frame buffer read address |
| zone_idx | output | ZONE_BITS (5) | Zone of the current word, for the partition latch |
| zones_loaded | output | 1 | One-cycle pulse after the last zone of a group |
| row_en | output | 1 | Duty-cycle row-scan enable |

## Verification
The bench steps through a whole frame, zone by zone, with a small column count. At each carry boundary it compares the address against an independent digit model. A design that carried on the wrong digit, or at 2^n instead of COLS, would present the wrong column or row right at the wrap.

Over one frame the bench counts the cycles spent on each field and the enabled cycles spent in each row. A bad step-to-field map would show up as wrong repeat counts. A bad default or comparison would show up as wrong on-time totals for fields 1 and 0.

The bench also writes an on-time of 0 and one of 10, pauses `run` with an address mid-row, and checks that the strobe lands only on zone 0 and only once.

// File: rtl/zfs_pkg.sv
package zfs_pkg;

  // Number of sub-field steps: heavy planes repeat in powers of two,
  // the lowest DUTY planes appear once each.
  function automatic int unsigned steps_for(input int unsigned fields,
                                            input int unsigned duty);
    steps_for = (32'd1 << (fields - duty)) - 32'd1 + duty;
  endfunction

  // Field shown during a given sub-field step (highest weight first).
  function automatic int unsigned field_of_step(input int unsigned step,
                                                input int unsigned fields,
                                                input int unsigned duty);
    int unsigned rem;
    int unsigned reps;
    bit          found;
    int unsigned f;
    rem   = step;
    found = 1'b0;
    field_of_step = 0;
    for (int i = 0; i < 32; i++) begin
      if (!found && i < int'(fields)) begin
        f    = fields - 1 - int'(i);
        reps = (f >= duty) ? (32'd1 << (f - duty)) : 32'd1;
        if (rem < reps) begin
          field_of_step = f;
          found = 1'b1;
        end else begin
          rem = rem - reps;
        end
      end
    end
  endfunction

  // Reset on-time: full period, except fields 1 and 0 (half, quarter).
  function automatic int unsigned default_on_time(input int unsigned field,
                                                  input int unsigned period);
    default_on_time = (field >= 2) ? period : (period >> (2 - field));
  endfunction

endpackage

// File: rtl/zfs_addr_counter.sv
module zfs_addr_counter #(
  parameter int ZB    = 5,
  parameter int CB    = 7,
  parameter int COLS  = 100,
  parameter int RB    = 3,
  parameter int SB    = 5,
  parameter int STEPS = 19
) (
  input  logic          clk,
  input  logic          rst_ln,
  input  logic          adv,
  output logic [ZB-1:0] area_o,
  output logic [CB-1:0] col_o,
  output logic [RB-1:0] row_o,
  output logic [SB-1:0] step_o,
  output logic          area_last_o,
  output logic          row_period_end_o
);

  localparam logic [ZB-1:0] AREA_MAX = {ZB{1'b1}};
  localparam logic [CB-1:0] COL_MAX  = CB'(COLS - 1);
  localparam logic [RB-1:0] ROW_MAX  = {RB{1'b1}};
  localparam logic [SB-1:0] STEP_MAX = SB'(STEPS - 1);

  logic [ZB-1:0] area_q, area_d;
  logic [CB-1:0] col_q, col_d;
  logic [RB-1:0] row_q, row_d;
  logic [SB-1:0] step_q, step_d;
  logic area_last, col_last, row_last, step_last;
  logic col_ce, row_ce, step_ce;

  always_comb begin
    area_last = (area_q == AREA_MAX);
    col_last  = (col_q == COL_MAX);
    row_last  = (row_q == ROW_MAX);
    step_last = (step_q == STEP_MAX);
    col_ce    = adv & area_last;
    row_ce    = col_ce & col_last;
    step_ce   = row_ce & row_last;

    area_d = area_q;
    col_d  = col_q;
    row_d  = row_q;
    step_d = step_q;
    if (adv)     area_d = area_last ? '0 : area_q + 1'b1;
    if (col_ce)  col_d  = col_last  ? '0 : col_q + 1'b1;
    if (row_ce)  row_d  = row_last  ? '0 : row_q + 1'b1;
    if (step_ce) step_d = step_last ? '0 : step_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) begin
      area_q <= '0;
      col_q  <= '0;
      row_q  <= '0;
      step_q <= '0;
    end else begin
      area_q <= area_d;
      col_q  <= col_d;
      row_q  <= row_d;
      step_q <= step_d;
    end
  end

  assign area_o           = area_q;
  assign col_o            = col_q;
  assign row_o            = row_q;
  assign step_o           = step_q;
  assign area_last_o      = area_last;
  assign row_period_end_o = area_last & col_last;

endmodule

// File: rtl/zfs_on_time_bank.sv
module zfs_on_time_bank #(
  parameter int FIELDS = 8,
  parameter int FB     = 3,
  parameter int TW     = 12,
  parameter int PERIOD = 3200
) (
  input  logic          clk,
  input  logic          rst_ln,
  input  logic          we,
  input  logic [FB-1:0] wfield,
  input  logic [TW-1:0] wvalue,
  input  logic [FB-1:0] sel,
  output logic [TW-1:0] on_time_o
);

  logic [TW-1:0] bank [FIELDS];

  for (genvar f = 0; f < FIELDS; f++) begin : g_entry
    localparam logic [TW-1:0] RST_VAL =
      TW'(zfs_pkg::default_on_time(f, PERIOD));
    logic          hit;
    logic [TW-1:0] val_q, val_d;

    always_comb begin
      hit   = we && (wfield == FB'(f));
      val_d = hit ? wvalue : val_q;
    end

    always_ff @(posedge clk or negedge rst_ln) begin
      if (!rst_ln) val_q <= RST_VAL;
      else         val_q <= val_d;
    end

    assign bank[f] = val_q;
  end

  assign on_time_o = bank[sel];

endmodule

// File: rtl/zfs_duty_gen.sv
module zfs_duty_gen #(
  parameter int TW = 12
) (
  input  logic          clk,
  input  logic          rst_ln,
  input  logic          adv,
  input  logic          restart,
  input  logic [TW-1:0] on_time,
  output logic          en_o
);

  logic [TW-1:0] timer_q, timer_d;

  always_comb begin
    timer_d = timer_q;
    if (adv) timer_d = restart ? '0 : timer_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) timer_q <= '0;
    else         timer_q <= timer_d;
  end

  assign en_o = (timer_q < on_time);

endmodule

// File: rtl/zone_field_sequencer.sv
module zone_field_sequencer #(
  parameter int ZONE_BITS   = 5,
  parameter int COLS        = 100,
  parameter int ROW_BITS    = 3,
  parameter int FIELDS      = 8,
  parameter int DUTY_FIELDS = 4,
  localparam int CB     = $clog2(COLS),
  localparam int FB     = $clog2(FIELDS),
  localparam int STEPS  = int'(zfs_pkg::steps_for(FIELDS, DUTY_FIELDS)),
  localparam int SB     = $clog2(STEPS),
  localparam int PERIOD = (1 << ZONE_BITS) * COLS,
  localparam int TW     = $clog2(PERIOD + 1),
  localparam int AW     = FB + ZONE_BITS + ROW_BITS + CB
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 run,
  input  logic                 cfg_we,
  input  logic [FB-1:0]        cfg_field,
  input  logic [TW-1:0]        cfg_value,
  output logic [AW-1:0]        rd_addr,
  output logic [ZONE_BITS-1:0] zone_idx,
  output logic                 zones_loaded,
  output logic                 row_en
);

  // Reset synchronizer: asserts at once, releases on the clock.
  logic rst_meta, rst_ln;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_ln   <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_ln   <= rst_meta;
    end
  end

  logic [ZONE_BITS-1:0] area;
  logic [CB-1:0]        col;
  logic [ROW_BITS-1:0]  row;
  logic [SB-1:0]        step;
  logic [FB-1:0]        field;
  logic                 area_last, row_end;
  logic [TW-1:0]        on_time;
  logic                 strobe_q, strobe_d;

  zfs_addr_counter #(
    .ZB(ZONE_BITS), .CB(CB), .COLS(COLS), .RB(ROW_BITS),
    .SB(SB), .STEPS(STEPS)
  ) u_cnt (
    .clk(clk), .rst_ln(rst_ln), .adv(run),
    .area_o(area), .col_o(col), .row_o(row), .step_o(step),
    .area_last_o(area_last), .row_period_end_o(row_end)
  );

  assign field = FB'(zfs_pkg::field_of_step(32'(step), FIELDS, DUTY_FIELDS));

  zfs_on_time_bank #(
    .FIELDS(FIELDS), .FB(FB), .TW(TW), .PERIOD(PERIOD)
  ) u_bank (
    .clk(clk), .rst_ln(rst_ln), .we(cfg_we), .wfield(cfg_field),
    .wvalue(cfg_value), .sel(field), .on_time_o(on_time)
  );

  zfs_duty_gen #(.TW(TW)) u_duty (
    .clk(clk), .rst_ln(rst_ln), .adv(run), .restart(row_end),
    .on_time(on_time), .en_o(row_en)
  );

  always_comb strobe_d = run & area_last;

  always_ff @(posedge clk or negedge rst_ln) begin
    if (!rst_ln) strobe_q <= 1'b0;
    else         strobe_q <= strobe_d;
  end

  assign rd_addr      = {field, area, row, col};
  assign zone_idx     = area;
  assign zones_loaded = strobe_q;

endmodule

// File: rtl/zfs_checks.sv
module zfs_checks #(
  parameter int ZB   = 5,
  parameter int CB   = 7,
  parameter int RB   = 3,
  parameter int FB   = 3,
  parameter int COLS = 100,
  parameter int AW   = 18
) (
  input logic          clk,
  input logic          rst_ln,
  input logic          run,
  input logic [AW-1:0] rd_addr,
  input logic [ZB-1:0] zone_idx,
  input logic          zones_loaded
);

  logic [FB-1:0] fld;
  logic [RB-1:0] row;
  logic [CB-1:0] col;
  assign fld = rd_addr[AW-1 -: FB];
  assign row = rd_addr[CB+RB-1 -: RB];
  assign col = rd_addr[CB-1:0];

  // R2: zone digit steps by one (natural 2^ZB wrap) on every run cycle
  a_r2_zone_steps: assert property (@(posedge clk) disable iff (!rst_ln)
    run |=> zone_idx == $past(zone_idx) + 1'b1);

  // R3: column carries only from the last zone
  a_r3_col_carry: assert property (@(posedge clk) disable iff (!rst_ln)
    (run && zone_idx == {ZB{1'b1}} && col != CB'(COLS - 1))
      |=> col == $past(col) + 1'b1);

  // R5: the shown field changes only at the end of a row-7 period
  a_r5_field_at_sweep_end: assert property (@(posedge clk) disable iff (!rst_ln)
    !$stable(fld) |-> $past(run && zone_idx == {ZB{1'b1}} &&
                            col == CB'(COLS - 1) && row == {RB{1'b1}}));

  // R7: strobe coincides with zone 0 and lasts one cycle
  a_r7_strobe_zone0: assert property (@(posedge clk) disable iff (!rst_ln)
    zones_loaded |-> zone_idx == '0);
  a_r7_strobe_single: assert property (@(posedge clk) disable iff (!rst_ln)
    zones_loaded |=> !zones_loaded);

  // R11: paused sequencer holds its address and raises no strobe
  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_ln)
    !run |=> ($stable(rd_addr) && !zones_loaded));

endmodule

bind zone_field_sequencer zfs_checks #(
  .ZB(ZONE_BITS), .CB(CB), .RB(ROW_BITS), .FB(FB), .COLS(COLS), .AW(AW)
) u_checks (
  .clk(clk), .rst_ln(rst_ln), .run(run), .rd_addr(rd_addr),
  .zone_idx(zone_idx), .zones_loaded(zones_loaded)
);

// File: tb/zone_field_sequencer_test.sv
module zone_field_sequencer_test;

  localparam int ZB = 5, COLS = 3, RB = 3, CB = 2, FB = 3;
  localparam int ZONES = 32, ROWS = 8, STEPS = 19;
  localparam int PERIOD = ZONES * COLS;          // 96
  localparam int TW = 7, AW = FB + ZB + RB + CB; // 13
  localparam int FRAME = STEPS * ROWS * PERIOD;  // 14592

  logic          clk = 1'b0;
  logic          rst_n, run, cfg_we;
  logic [FB-1:0] cfg_field;
  logic [TW-1:0] cfg_value;
  logic [AW-1:0] rd_addr;
  logic [ZB-1:0] zone_idx;
  logic          zones_loaded, row_en;

  always #5 clk = ~clk;

  zone_field_sequencer #(.ZONE_BITS(ZB), .COLS(COLS), .ROW_BITS(RB)) uut (
    .clk(clk), .rst_n(rst_n), .run(run), .cfg_we(cfg_we),
    .cfg_field(cfg_field), .cfg_value(cfg_value), .rd_addr(rd_addr),
    .zone_idx(zone_idx), .zones_loaded(zones_loaded), .row_en(row_en)
  );

  int total = 0, bad = 0;
  bit finished = 1'b0;

  // independent model
  int m_area, m_col, m_row, m_step, m_strobe;
  int m_on [8];

  function automatic int exp_field(input int s);
    if (s < 8)        return 7;
    else if (s < 12)  return 6;
    else if (s < 14)  return 5;
    else if (s == 14) return 4;
    else              return 18 - s;
  endfunction

  function automatic int cur_field();
    return exp_field(m_step);
  endfunction

  task automatic check(input string tag, input int act, input int exp_v);
    total++;
    if (act != exp_v) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp_v);
    end
  endtask

  task automatic check_all();
    int ea, timer;
    ea = (cur_field() << (ZB + RB + CB)) | (m_area << (RB + CB)) |
         (m_row << CB) | m_col;
    timer = m_col * ZONES + m_area;
    check("R6 address", int'(rd_addr), ea);
    check("R2 zone_idx", int'(zone_idx), m_area);
    check("R7 zones_loaded", int'(zones_loaded), m_strobe);
    check("R8 row_en", int'(row_en), (timer < m_on[cur_field()]) ? 1 : 0);
  endtask

  // one cycle: drive at negedge, update model at posedge, back to negedge
  task automatic cycle(input bit r);
    run = r;
    @(posedge clk);
    m_strobe = (r && m_area == ZONES - 1) ? 1 : 0;
    if (r) begin
      if (m_area == ZONES - 1) begin
        if (m_col == COLS - 1) begin
          if (m_row == ROWS - 1) m_step = (m_step == STEPS - 1) ? 0 : m_step + 1;
          m_row = (m_row == ROWS - 1) ? 0 : m_row + 1;
        end
        m_col = (m_col == COLS - 1) ? 0 : m_col + 1;
      end
      m_area = (m_area == ZONES - 1) ? 0 : m_area + 1;
    end
    @(negedge clk);
  endtask

  task automatic write_on(input int f, input int v);
    cfg_we = 1'b1; cfg_field = FB'(f); cfg_value = TW'(v);
    cycle(1'b0);
    m_on[f] = v;
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; run = 1'b0; cfg_we = 1'b0; cfg_field = '0; cfg_value = '0;
    m_area = 0; m_col = 0; m_row = 0; m_step = 0; m_strobe = 0;
    for (int f = 0; f < 8; f++) m_on[f] = (f >= 2) ? PERIOD : (PERIOD >> (2 - f));
    repeat (3) @(negedge clk);
    check("R1 reset address", int'(rd_addr), 7 << (ZB + RB + CB));
    check("R1 reset strobe", int'(zones_loaded), 0);
    check("R1 reset row_en", int'(row_en), 1);
    rst_n = 1'b1;
    repeat (4) cycle(1'b0);
    check_all();
  endtask

  task automatic t_zone_sweep();
    for (int i = 0; i < 31; i++) begin
      cycle(1'b1);
      check_all();
      check("R7 no early strobe", int'(zones_loaded), 0);
    end
    check("R2 zone at 31", int'(zone_idx), 31);
    cycle(1'b1);
    check("R2 zone wraps to 0", int'(zone_idx), 0);
    check("R7 strobe after wrap", int'(zones_loaded), 1);
    check("R3 column advanced", int'(rd_addr[CB-1:0]), 1);
    cycle(1'b1);
    check("R7 strobe one cycle", int'(zones_loaded), 0);
    check_all();
  endtask

  task automatic t_hold();
    logic [AW-1:0] held;
    logic          en_held;
    repeat (7) cycle(1'b1);
    held = rd_addr; en_held = row_en;
    for (int i = 0; i < 5; i++) begin
      cycle(1'b0);
      check("R11 address held", int'(rd_addr), int'(held));
      check("R11 enable held", int'(row_en), int'(en_held));
      check("R11 no strobe", int'(zones_loaded), 0);
    end
    check_all();
  endtask

  // run to the start of a row period, then count enable over one row
  task automatic row_on_count(output int cnt);
    cnt = 0;
    for (int i = 0; i < PERIOD; i++) begin
      cnt += int'(row_en);
      check_all();
      cycle(1'b1);
    end
  endtask

  task automatic t_on_time_write();
    int cnt;
    while (!(m_area == 0 && m_col == 0)) cycle(1'b1);
    write_on(7, 0);
    check("R10 zero on-time", int'(row_en), 0);
    row_on_count(cnt);
    check("R10 zero on-time row count", cnt, 0);
    write_on(7, 10);
    row_on_count(cnt);
    check("R10 on-time 10 row count", cnt, 10);
    write_on(7, PERIOD);
    check_all();
  endtask

  task automatic t_frame();
    int fcyc [8];
    int fon  [8];
    int carries_col = 0, carries_row = 0;
    for (int f = 0; f < 8; f++) begin fcyc[f] = 0; fon[f] = 0; end
    for (int i = 0; i < FRAME; i++) begin
      int fsh, oc, orw;
      fsh = int'(rd_addr[AW-1 -: FB]);
      fcyc[fsh]++;
      fon[fsh] += int'(row_en);
      oc = m_col; orw = m_row;
      cycle(1'b1);
      check_all();
      if (oc == COLS - 1 && m_col == 0) carries_col++;
      if (orw == ROWS - 1 && m_row == 0) carries_row++;
    end
    check("R3 column wraps per frame", carries_col, STEPS * ROWS);
    check("R4 row wraps per frame", carries_row, STEPS);
    check("R5 field7 repeats", fcyc[7], 8 * ROWS * PERIOD);
    check("R5 field6 repeats", fcyc[6], 4 * ROWS * PERIOD);
    check("R5 field5 repeats", fcyc[5], 2 * ROWS * PERIOD);
    check("R5 field4 once", fcyc[4], ROWS * PERIOD);
    check("R5 field0 once", fcyc[0], ROWS * PERIOD);
    check("R9 field2 full", fon[2], ROWS * PERIOD);
    check("R9 field1 half", fon[1], ROWS * PERIOD / 2);
    check("R9 field0 quarter", fon[0], ROWS * PERIOD / 4);
  endtask

  initial begin
    t_reset();
    t_zone_sweep();
    t_hold();
    t_on_time_write();
    t_frame();
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule